// File: doc/BRIEF.md
# Bank-Level Hit Cluster Finder

This block takes one 64-column slice of a discriminated pixel row and turns its hit pattern into a short list of clusters, here called states. A state is a run of adjacent hit pixels no wider than four columns. It is reported as the column of its first pixel and its pixel count. The block keeps a fixed budget of six states per row. Hits left after the sixth state are dropped, and an overflow flag is raised in their place.

The search is pipelined. Each stage claims the lowest-column run that no earlier stage has taken, so the list comes out in increasing column order. A run wider than four pixels is cut into consecutive states. A new row can be accepted on every clock. Each result appears a fixed number of cycles after its row was sampled, which keeps the block well inside the row period when several banks of a wider row work side by side.

Top module: `bank_cluster_finder`

## Requirements
- R1: While reset is low and after it is released, `done`, `state_cnt` and `overflow` read zero until a row has been accepted.
- R2: A row sampled with `row_valid` high on a rising edge produces `done` high for exactly one cycle, after the sixth rising edge that follows the sampling edge.
- R3: Bit i of `row_hits` is column i. Slot k of the list holds a 6-bit first-column address at `state_addr[6k+5:6k]` and a 2-bit width code at `state_len[2k+1:2k]`, equal to the pixel count minus one.
- R4: States fill slots from slot 0 in strictly increasing column order. Every slot at or above `state_cnt` reads zero in both lists.
- R5: A run of more than four adjacent hits is reported as consecutive states of four pixels, followed by one state holding the remainder. Each of these states starts at the first column not claimed by the state before it.
- R6: `state_cnt` gives the number of states in the list and never exceeds six.
- R7: With `done`, `overflow` is high exactly when hit columns remain after six states have been taken. When it is high, `state_cnt` is six.
- R8: `row_hits` sampled while `row_valid` is low produces no `done` and no state.
- R9: A valid row with no hits gives `done` with `state_cnt` zero, `overflow` low and all slots zero.
- R10: Rows presented on back-to-back cycles are each reported on their own cycle, with no mixing of their results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_valid | input | 1 | Row-valid strobe that starts a search |
| row_hits | input | 64 | Discriminator outputs of the bank, one bit per column |
| done | output | 1 | One-cycle pulse marking a stable result |
| state_cnt | output | 3 | Number of states found (0 to 6) |
| overflow | output | 1 | Hits were dropped beyond the sixth state |
| state_addr | output | 36 | Six 6-bit first-column addresses, slot 0 in the low bits |
| state_len | output | 12 | Six 2-bit width codes (count minus one), slot 0 in the low bits |

## Verification
The sixth state and the overflow flag can both come from the same row and show up in the same `done` cycle. The same happens when the sixth state is the middle piece of a split long run. Directed rows put 24 and 25 adjacent hits at the bottom of the bank, and six and seven isolated hits. In each case the bench checks that the sixth slot holds the right address and width code and that the flag rises only when a column really remains. Dense random rows then cover many more rows that sit right at the six-state budget, with results arriving back to back. Every row is compared against a reference cluster search written in the bench.

// File: rtl/clf_pkg.sv
// Package: default geometry of the bank cluster finder.
// Assumes: all modules derive their widths from these values.
package clf_pkg;
    localparam int BANK_COLS_DEF = 64;  // columns scanned per bank
    localparam int MAX_STATES_DEF = 6;  // state budget per row
    localparam int RUN_MAX_DEF = 4;     // widest state in pixels
endpackage

// File: rtl/clf_extract.sv
// Module: clf_extract
// Finds the lowest-column hit in a mask, measures the run starting there
// (capped at RUN_MAX pixels), and returns the mask with that run removed.
// Assumes: purely combinational; RUN_MAX >= 2 and a power of two.
module clf_extract #(
    parameter int NCOL = clf_pkg::BANK_COLS_DEF,
    parameter int RUN_MAX = clf_pkg::RUN_MAX_DEF,
    localparam int AW = $clog2(NCOL),
    localparam int LW = $clog2(RUN_MAX),
    localparam int RW = $clog2(RUN_MAX + 1)
) (
    input  logic [NCOL-1:0] mask_i,
    output logic            found_o,
    output logic [AW-1:0]   addr_o,
    output logic [LW-1:0]   code_o,
    output logic [NCOL-1:0] mask_o
);
    logic [AW-1:0]   first_col;
    logic            any_hit;
    logic [NCOL-1:0] aligned;
    logic [RW-1:0]   run_len;
    logic            still_run;
    logic [NCOL-1:0] claim;

    // Priority search: the lowest set column wins.
    always_comb begin
        any_hit = 1'b0;
        first_col = '0;
        for (int i = NCOL - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                any_hit = 1'b1;
                first_col = AW'(i);
            end
        end
    end

    // Measure the run from the first column, stopping at RUN_MAX pixels.
    always_comb begin
        aligned = mask_i >> first_col;
        run_len = RW'(1);
        still_run = 1'b1;
        for (int k = 1; k < RUN_MAX; k++) begin
            still_run = still_run & aligned[k];
            if (still_run) begin
                run_len = run_len + RW'(1);
            end
        end
    end

    // Remove the claimed columns and present the state fields.
    always_comb begin
        claim = ((NCOL'(1) << run_len) - NCOL'(1)) << first_col;
        found_o = any_hit;
        addr_o = any_hit ? first_col : '0;
        code_o = any_hit ? LW'(run_len - RW'(1)) : '0;
        mask_o = any_hit ? (mask_i & ~claim) : mask_i;
    end
endmodule

// File: rtl/clf_stage.sv
// Module: clf_stage
// One pipeline stage: it claims the next state from the remaining mask, writes
// it into list slot SLOT, and passes the rest of the list and mask forward.
// Assumes: earlier slots are already filled in column order; slots at and
// above SLOT arrive zero.
module clf_stage #(
    parameter int NCOL = clf_pkg::BANK_COLS_DEF,
    parameter int NSTATE = clf_pkg::MAX_STATES_DEF,
    parameter int RUN_MAX = clf_pkg::RUN_MAX_DEF,
    parameter int SLOT = 0,
    localparam int AW = $clog2(NCOL),
    localparam int LW = $clog2(RUN_MAX),
    localparam int CW = $clog2(NSTATE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [NCOL-1:0]      mask_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic [NSTATE*AW-1:0] addr_i,
    input  logic [NSTATE*LW-1:0] code_i,
    output logic                 valid_o,
    output logic [NCOL-1:0]      mask_o,
    output logic [CW-1:0]        cnt_o,
    output logic [NSTATE*AW-1:0] addr_o,
    output logic [NSTATE*LW-1:0] code_o
);
    localparam int PREV = (SLOT > 0) ? SLOT - 1 : 0;

    logic            hit_found;
    logic [AW-1:0]   hit_addr;
    logic [LW-1:0]   hit_code;
    logic [NCOL-1:0] rest_mask;
    logic [NSTATE*AW-1:0] addr_nxt;
    logic [NSTATE*LW-1:0] code_nxt;

    clf_extract #(.NCOL(NCOL), .RUN_MAX(RUN_MAX)) u_find (
        .mask_i (mask_i),
        .found_o(hit_found),
        .addr_o (hit_addr),
        .code_o (hit_code),
        .mask_o (rest_mask)
    );

    // Insert this stage's state into its own slot.
    always_comb begin
        addr_nxt = addr_i;
        code_nxt = code_i;
        addr_nxt[SLOT*AW +: AW] = hit_addr;
        code_nxt[SLOT*LW +: LW] = hit_code;
    end

    // Register the stage result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            mask_o  <= '0;
            cnt_o   <= '0;
            addr_o  <= '0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            mask_o  <= rest_mask;
            cnt_o   <= cnt_i + CW'(hit_found);
            addr_o  <= addr_nxt;
            code_o  <= code_nxt;
        end
    end

    // Marks the cycles in which $past values come from out of reset.
    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R5
    run_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && valid_o && (cnt_o != $past(cnt_i))) |->
        ($countones(mask_o) + int'(code_o[SLOT*LW +: LW]) + 1 == $countones($past(mask_i))));

    // R9
    empty_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && valid_o && (cnt_o == $past(cnt_i))) |-> (mask_o == '0));

    generate
        if (SLOT > 0) begin : g_order
            // R4
            col_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && valid_o && (int'(cnt_o) == SLOT + 1)) |->
                (int'(addr_o[SLOT*AW +: AW]) >
                 int'(addr_o[PREV*AW +: AW]) + int'(code_o[PREV*LW +: LW])));
        end
    endgenerate
endmodule

// File: rtl/bank_cluster_finder.sv
// Module: bank_cluster_finder
// Turns one bank of discriminated pixel hits into at most NSTATE states
// (first column and width code), in increasing column order, with an
// overflow flag. It accepts one row per cycle and answers after NSTATE cycles.
// Assumes: row_hits is stable while row_valid is high on the sampling edge.
module bank_cluster_finder #(
    parameter int NCOL = clf_pkg::BANK_COLS_DEF,
    parameter int NSTATE = clf_pkg::MAX_STATES_DEF,
    parameter int RUN_MAX = clf_pkg::RUN_MAX_DEF,
    localparam int AW = $clog2(NCOL),
    localparam int LW = $clog2(RUN_MAX),
    localparam int CW = $clog2(NSTATE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 row_valid,
    input  logic [NCOL-1:0]      row_hits,
    output logic                 done,
    output logic [CW-1:0]        state_cnt,
    output logic                 overflow,
    output logic [NSTATE*AW-1:0] state_addr,
    output logic [NSTATE*LW-1:0] state_len
);
    logic            cap_v;
    logic [NCOL-1:0] cap_m;

    logic                 st_v [NSTATE];
    logic [NCOL-1:0]      st_m [NSTATE];
    logic [CW-1:0]        st_c [NSTATE];
    logic [NSTATE*AW-1:0] st_a [NSTATE];
    logic [NSTATE*LW-1:0] st_l [NSTATE];

    // Capture a row; masked hits keep an invalid row from carrying data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v <= 1'b0;
            cap_m <= '0;
        end else begin
            cap_v <= row_valid;
            cap_m <= row_valid ? row_hits : '0;
        end
    end

    generate
        for (genvar g = 0; g < NSTATE; g++) begin : g_stage
            if (g == 0) begin : g_head
                clf_stage #(.NCOL(NCOL), .NSTATE(NSTATE), .RUN_MAX(RUN_MAX), .SLOT(g)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .valid_i(cap_v), .mask_i(cap_m), .cnt_i('0), .addr_i('0), .code_i('0),
                    .valid_o(st_v[g]), .mask_o(st_m[g]), .cnt_o(st_c[g]),
                    .addr_o(st_a[g]), .code_o(st_l[g])
                );
            end else begin : g_body
                clf_stage #(.NCOL(NCOL), .NSTATE(NSTATE), .RUN_MAX(RUN_MAX), .SLOT(g)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .valid_i(st_v[g-1]), .mask_i(st_m[g-1]), .cnt_i(st_c[g-1]),
                    .addr_i(st_a[g-1]), .code_i(st_l[g-1]),
                    .valid_o(st_v[g]), .mask_o(st_m[g]), .cnt_o(st_c[g]),
                    .addr_o(st_a[g]), .code_o(st_l[g])
                );
            end
        end
    endgenerate

    // Present the last stage; leftover columns mean dropped clusters.
    always_comb begin
        done       = st_v[NSTATE-1];
        state_cnt  = st_c[NSTATE-1];
        overflow   = st_v[NSTATE-1] & (|st_m[NSTATE-1]);
        state_addr = st_a[NSTATE-1];
        state_len  = st_l[NSTATE-1];
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(state_cnt) <= NSTATE);

    // R7
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (int'(state_cnt) == NSTATE));

    // R7
    overflow_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> done);
endmodule

// File: tb/sim_bank_cluster_finder.sv
`timescale 1ns/1ps
module sim_bank_cluster_finder;
    localparam int NCOL = 64;
    localparam int NSTATE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_valid = 1'b0;
    logic [63:0] row_hits = '0;
    logic        done;
    logic [2:0]  state_cnt;
    logic        overflow;
    logic [35:0] state_addr;
    logic [11:0] state_len;

    always #4 clk = ~clk;

    bank_cluster_finder u0 (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_hits(row_hits),
        .done(done), .state_cnt(state_cnt), .overflow(overflow),
        .state_addr(state_addr), .state_len(state_len)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic        hv [8];
    logic [63:0] hh [8];
    string       ht [8];

    // Reference: greedy lowest-column search, runs capped at four pixels.
    function automatic void ref_model(input logic [63:0] h, output int cnt,
                                      output logic ovf, output logic [35:0] al,
                                      output logic [11:0] ll);
        logic [63:0] m;
        int c;
        int n;
        m = h;
        cnt = 0;
        al = '0;
        ll = '0;
        while (cnt < NSTATE && m != 0) begin
            c = 0;
            while (!m[c]) c++;
            n = 0;
            while (n < 4 && (c + n) < NCOL) begin
                if (!m[c+n]) break;
                m[c+n] = 1'b0;
                n++;
            end
            al[cnt*6 +: 6] = 6'(c);
            ll[cnt*2 +: 2] = 2'(n - 1);
            cnt++;
        end
        ovf = (m != 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Check the row driven seven falling edges ago, then drive a new one.
    task automatic step(input logic v, input logic [63:0] h, input string tag);
        int cnt;
        logic ovf;
        logic [35:0] al;
        logic [11:0] ll;
        @(negedge clk);
        if (hv[6]) begin
            ref_model(hh[6], cnt, ovf, al, ll);
            chk(done === 1'b1, {ht[6], " R2"}, "done", 64'(done), 64'd1);
            chk(state_cnt === 3'(cnt), {ht[6], " R6"}, "state_cnt", 64'(state_cnt), 64'(cnt));
            chk(overflow === ovf, {ht[6], " R7"}, "overflow", 64'(overflow), 64'(ovf));
            chk(state_addr === al, {ht[6], " R3 R4 R5"}, "state_addr", 64'(state_addr), 64'(al));
            chk(state_len === ll, {ht[6], " R3 R4 R5"}, "state_len", 64'(state_len), 64'(ll));
        end else begin
            chk(done === 1'b0, {ht[6], " R8"}, "done", 64'(done), 64'd0);
        end
        for (int k = 7; k > 0; k--) begin
            hv[k] = hv[k-1];
            hh[k] = hh[k-1];
            ht[k] = ht[k-1];
        end
        hv[0] = v;
        hh[0] = h;
        ht[0] = tag;
        row_valid = v;
        row_hits = h;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        int mode;
        for (int k = 0; k < 8; k++) begin
            hv[k] = 1'b0;
            hh[k] = '0;
            ht[k] = "idle";
        end
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done === 1'b0, "R1", "done", 64'(done), 64'd0);
        chk(state_cnt === 3'd0, "R1", "state_cnt", 64'(state_cnt), 64'd0);
        chk(overflow === 1'b0, "R1", "overflow", 64'(overflow), 64'd0);

        // Directed corner cases, presented back to back (R10)
        step(1'b1, 64'h0, "R9 empty row");
        step(1'b0, '1, "R8 ignored full row");
        step(1'b1, 64'h0000_0000_00FF_FFFF, "R5 24 adjacent exact six");
        step(1'b1, 64'h0000_0000_01FF_FFFF, "R7 25 adjacent overflow");
        step(1'b1, '1, "R7 full row");
        step(1'b1, 64'h0000_0000_0055_5555 & 64'h0000_0000_0000_0555, "R4 six isolated");
        step(1'b1, 64'h0000_0000_0000_1555, "R7 seven isolated");
        step(1'b1, 64'h8000_0000_0000_0000, "R3 top column");
        step(1'b1, 64'hE000_0000_0000_0001, "R3 edges");
        step(1'b1, 64'hF800_0000_0000_0000, "R5 five at top");
        step(1'b0, 64'h0000_0000_0000_00FF, "R8 ignored run");
        step(1'b1, 64'h0000_0000_0000_007F, "R5 seven adjacent");
        step(1'b1, 64'h0000_0000_0000_0E0F, "R10 mixed widths");

        // Constrained random rows of varied density
        for (int i = 0; i < 3000; i++) begin
            mode = int'($urandom_range(0, 3));
            r = {$urandom, $urandom};
            case (mode)
                0: r = r & {$urandom, $urandom} & {$urandom, $urandom};
                1: r = r & {$urandom, $urandom};
                2: r = r | {$urandom, $urandom};
                default: ;
            endcase
            step(($urandom_range(0, 4) != 0), r, "R10 random");
        end
        for (int i = 0; i < 8; i++) step(1'b0, '0, "R8 flush");
        finished = 1;
        summary();
        $finish;
    end
endmodule